// File: doc/BRIEF.md
# Watchdog Timer with Divider Recovery

This block is a watchdog timer for a programmable clock generator, set up through three byte-wide registers. Firmware sets a timeout and turns the watchdog on. The timeout is a 3-bit count multiplied by a selectable time unit. The unit is either short or long, and it is built by counting pulses of a free-running reference tick. From then on, every write to the control byte restarts the countdown. If that write stops coming, the countdown runs out.

On expiry the block sets a readable alarm flag and pulls an active-low system reset low for a fixed number of clock cycles. It stays in the expired state until software writes the control byte again. An action-select bit chooses what else happens. In one setting the block only pulses the reset. In the other it also locks the divider outputs to a recovery setting. That setting is either the hardware default divider or the programmed 9-bit N and 7-bit M held in the registers. Outside of recovery, the divider outputs follow a programmed-mode input pin.

Top module: `wdt_freq_recover`

## Requirements
- R1: After `rst` the control byte (address 0) reads 0x20, addresses 1 and 2 read 0x00, `sys_rst_n` is 1 and, with `prog_en` low, `n_out`/`m_out` equal `hw_n`/`hw_m`.
- R2: Address 0 layout, MSB to LSB: bit 7 N[8], bits 6:4 count code, bit 3 scale select, bit 2 action select, bit 1 alarm (read-only), bit 0 enable. Address 1 is {recovery select, M[6:0]}; address 2 is N[7:0]; address 3 reads 0. Read data is registered one cycle after the address is presented, and writes to bit 1 of address 0 have no effect.
- R3: With enable set and a count code k from 1 to 7, expiry occurs on the k*U-th `ref_tick` after the last control write. U is SHORT_TICKS when the scale bit is 0 and LONG_TICKS when it is 1. No expiry occurs earlier.
- R4: Count code 000 with enable set expires on the first `ref_tick`.
- R5: With the enable bit clear, no number of ticks causes an expiry.
- R6: A control-byte write while enabled restarts the full countdown.
- R7: On expiry the alarm bit reads 1. The watchdog does not re-arm or expire again until the next control write. Only a control write with count code 000 clears the alarm.
- R8: Each expiry drives `sys_rst_n` low for exactly RST_CYCLES clock cycles, once.
- R9: With action select 1, an expiry leaves `n_out`/`m_out` unchanged.
- R10: With action select 0 and recovery select 0, an expiry locks `n_out`/`m_out` to `hw_n`/`hw_m` until `rst`, whatever `prog_en` does.
- R11: With action select 0 and recovery select 1, an expiry locks `n_out`/`m_out` to the programmed {N[8], N[7:0]} and M until `rst`.
- R12: When not locked, `n_out`/`m_out` give the programmed N/M while `prog_en` is 1 and `hw_n`/`hw_m` while it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address for reads and writes |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Registered read data |
| ref_tick | input | 1 | One-cycle reference tick strobe |
| prog_en | input | 1 | Selects programmed dividers when not locked |
| hw_n | input | 9 | Hardware default N divider |
| hw_m | input | 7 | Hardware default M divider |
| sys_rst_n | output | 1 | Active-low system reset pulse |
| n_out | output | 9 | Active N divider |
| m_out | output | 7 | Active M divider |

## Verification
The assertions take `ref_tick` to be a one-cycle strobe that is synchronous to `clk`. They also take register writes to be single-cycle strobes, and they assume the scale lengths, RST_CYCLES and the count code are all nonzero where the timeout arithmetic relies on it. The stimulus drives every tick as a one-cycle high followed by a low cycle, and it issues each write or read as a separate one-cycle strobe. It changes parameters only through small bench overrides, so the whole timeout range stays within a few hundred cycles.

// File: rtl/wdt_freq_pkg.sv
package wdt_freq_pkg;
  localparam int N_W = 9;
  localparam int M_W = 7;
  localparam int CODE_W = 3;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_RCV  = 2'd1;
  localparam logic [1:0] ADDR_NLO  = 2'd2;

  typedef struct packed {
    logic              n_hi;
    logic [CODE_W-1:0] code;
    logic              scale;
    logic              act;
    logic              en;
  } ctrl_t;

  typedef enum logic [1:0] {
    SEL_FOLLOW = 2'd0,
    SEL_HW     = 2'd1,
    SEL_PROG   = 2'd2
  } sel_e;
endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_freq_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we_i,
  input  logic [1:0]       addr_i,
  input  logic [7:0]       wdata_i,
  input  logic             alarm_i,
  output logic [7:0]       rdata_o,
  output ctrl_t            ctrl_o,
  output logic             rcv_sel_o,
  output logic [M_W-1:0]   m_o,
  output logic [N_W-2:0]   nlo_o,
  output logic             ctrl_wr_o
);
  assign ctrl_wr_o = we_i && (addr_i == ADDR_CTRL);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_o    <= '{n_hi: 1'b0, code: 3'b010, scale: 1'b0, act: 1'b0, en: 1'b0};
      rcv_sel_o <= 1'b0;
      m_o       <= '0;
      nlo_o     <= '0;
      rdata_o   <= '0;
    end else begin
      if (we_i) begin
        unique case (addr_i)
          ADDR_CTRL: ctrl_o <= '{n_hi: wdata_i[7], code: wdata_i[6:4],
                                 scale: wdata_i[3], act: wdata_i[2], en: wdata_i[0]};
          ADDR_RCV: begin
            rcv_sel_o <= wdata_i[7];
            m_o       <= wdata_i[6:0];
          end
          ADDR_NLO: nlo_o <= wdata_i;
          default: ;
        endcase
      end
      unique case (addr_i)
        ADDR_CTRL: rdata_o <= {ctrl_o.n_hi, ctrl_o.code, ctrl_o.scale,
                               ctrl_o.act, alarm_i, ctrl_o.en};
        ADDR_RCV:  rdata_o <= {rcv_sel_o, m_o};
        ADDR_NLO:  rdata_o <= nlo_o;
        default:   rdata_o <= 8'h00;
      endcase
    end
  end

  // R2: the read-only alarm bit never reaches the stored control fields
  assert_ctrl_write_R2: assert property (@(posedge clk) disable iff (rst)
    ctrl_wr_o |=> (ctrl_o.en == $past(wdata_i[0])) && (ctrl_o.code == $past(wdata_i[6:4])));
endmodule

// File: rtl/wdt_timer.sv
module wdt_timer #(
  parameter int SHORT_TICKS = 294,
  parameter int LONG_TICKS  = 2340
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       en_i,
  input  logic       load_i,
  input  logic [2:0] code_i,
  input  logic       clr_alarm_i,
  input  logic       scale_i,
  input  logic       tick_i,
  output logic       tmo_o,
  output logic       alarm_o
);
  localparam int MAXT = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
  localparam int CW = $clog2(MAXT + 1);
  localparam logic [CW-1:0] SHORT_LAST = CW'(SHORT_TICKS - 1);
  localparam logic [CW-1:0] LONG_LAST  = CW'(LONG_TICKS - 1);

  logic [CW-1:0] pre_q;
  logic [2:0]    units_q;
  logic          expired_q;
  logic [CW-1:0] unit_last;

  assign unit_last = scale_i ? LONG_LAST : SHORT_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q     <= '0;
      units_q   <= '0;
      expired_q <= 1'b0;
      tmo_o     <= 1'b0;
      alarm_o   <= 1'b0;
    end else begin
      tmo_o <= 1'b0;
      if (clr_alarm_i) alarm_o <= 1'b0;
      if (load_i) begin
        units_q   <= code_i;
        pre_q     <= '0;
        expired_q <= 1'b0;
      end else if (en_i && !expired_q && tick_i) begin
        if (units_q == 3'd0) begin
          expired_q <= 1'b1;
          tmo_o     <= 1'b1;
          alarm_o   <= 1'b1;
        end else if (pre_q == unit_last) begin
          pre_q <= '0;
          if (units_q == 3'd1) begin
            expired_q <= 1'b1;
            tmo_o     <= 1'b1;
            alarm_o   <= 1'b1;
          end else begin
            units_q <= units_q - 3'd1;
          end
        end else begin
          pre_q <= pre_q + CW'(1);
        end
      end
    end
  end

  assert_no_fire_disabled_R5: assert property (@(posedge clk) disable iff (rst)
    !en_i |=> !tmo_o);
  assert_single_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    (tmo_o && !load_i) |=> !tmo_o);
  assert_alarm_on_expiry_R7: assert property (@(posedge clk) disable iff (rst)
    tmo_o |-> alarm_o);
endmodule

// File: rtl/wdt_rst_pulse.sv
module wdt_rst_pulse #(
  parameter int RST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic fire_i,
  output logic rst_n_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      rst_n_o <= 1'b1;
    end else if (fire_i) begin
      cnt_q   <= CW'(RST_CYCLES);
      rst_n_o <= 1'b0;
    end else if (cnt_q > CW'(1)) begin
      cnt_q <= cnt_q - CW'(1);
    end else if (cnt_q == CW'(1)) begin
      cnt_q   <= '0;
      rst_n_o <= 1'b1;
    end
  end

  assert_pulse_starts_R8: assert property (@(posedge clk) disable iff (rst)
    fire_i |=> !rst_n_o);
  assert_pulse_bound_R8: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= CW'(RST_CYCLES));
endmodule

// File: rtl/wdt_freq_recover.sv
module wdt_freq_recover
  import wdt_freq_pkg::*;
#(
  parameter int SHORT_TICKS = 294,
  parameter int LONG_TICKS  = 2340,
  parameter int RST_CYCLES  = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           reg_we,
  input  logic [1:0]     reg_addr,
  input  logic [7:0]     reg_wdata,
  output logic [7:0]     reg_rdata,
  input  logic           ref_tick,
  input  logic           prog_en,
  input  logic [N_W-1:0] hw_n,
  input  logic [M_W-1:0] hw_m,
  output logic           sys_rst_n,
  output logic [N_W-1:0] n_out,
  output logic [M_W-1:0] m_out
);
  ctrl_t          ctrl;
  logic           rcv_sel;
  logic [M_W-1:0] prog_m;
  logic [N_W-2:0] prog_nlo;
  logic           ctrl_wr;
  logic           alarm;
  logic           tmo;
  sel_e           sel_q;
  logic [N_W-1:0] prog_n;
  logic [N_W-1:0] n_nxt;
  logic [M_W-1:0] m_nxt;

  wdt_regs u_regs (
    .clk(clk), .rst(rst), .we_i(reg_we), .addr_i(reg_addr), .wdata_i(reg_wdata),
    .alarm_i(alarm), .rdata_o(reg_rdata), .ctrl_o(ctrl), .rcv_sel_o(rcv_sel),
    .m_o(prog_m), .nlo_o(prog_nlo), .ctrl_wr_o(ctrl_wr)
  );

  wdt_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_timer (
    .clk(clk), .rst(rst), .en_i(ctrl.en), .load_i(ctrl_wr),
    .code_i(reg_wdata[6:4]), .clr_alarm_i(ctrl_wr && (reg_wdata[6:4] == 3'd0)),
    .scale_i(ctrl.scale), .tick_i(ref_tick), .tmo_o(tmo), .alarm_o(alarm)
  );

  wdt_rst_pulse #(.RST_CYCLES(RST_CYCLES)) u_pulse (
    .clk(clk), .rst(rst), .fire_i(tmo), .rst_n_o(sys_rst_n)
  );

  assign prog_n = {ctrl.n_hi, prog_nlo};

  always_comb begin
    unique case (sel_q)
      SEL_HW:   begin n_nxt = hw_n;   m_nxt = hw_m;   end
      SEL_PROG: begin n_nxt = prog_n; m_nxt = prog_m; end
      default: begin
        n_nxt = prog_en ? prog_n : hw_n;
        m_nxt = prog_en ? prog_m : hw_m;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= SEL_FOLLOW;
      n_out <= '0;
      m_out <= '0;
    end else begin
      if (tmo && !ctrl.act && sel_q == SEL_FOLLOW)
        sel_q <= rcv_sel ? SEL_PROG : SEL_HW;
      n_out <= n_nxt;
      m_out <= m_nxt;
    end
  end

  assert_lock_on_reload_R10: assert property (@(posedge clk) disable iff (rst)
    (tmo && !ctrl.act) |=> (sel_q != SEL_FOLLOW));
  assert_no_lock_reset_only_R9: assert property (@(posedge clk) disable iff (rst)
    (sel_q == SEL_FOLLOW && !(tmo && !ctrl.act)) |=> (sel_q == SEL_FOLLOW));
  assert_lock_holds_R11: assert property (@(posedge clk) disable iff (rst)
    (sel_q != SEL_FOLLOW) |=> $stable(sel_q));
endmodule

// File: tb/sim_wdt_freq_recover.sv
module sim_wdt_freq_recover;
  localparam int SHORT = 3;
  localparam int LONG  = 5;
  localparam int RSTC  = 6;
  localparam logic [8:0] HWN = 9'h0A5;
  localparam logic [6:0] HWM = 7'h11;
  localparam logic [8:0] PGN = 9'h1C3;
  localparam logic [6:0] PGM = 7'h2D;
  // {code[2:0], scale, act, recov, prog_en, kick}
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{
    8'b001_0_1_0_0_0, 8'b011_0_0_1_0_1, 8'b010_1_0_0_1_0,
    8'b000_0_0_1_0_0, 8'b111_0_1_1_1_1, 8'b001_1_0_1_1_0};

  logic clk = 0, rst = 1, reg_we = 0, ref_tick = 0, prog_en = 0;
  logic [1:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic sys_rst_n;
  logic [8:0] n_out;
  logic [6:0] m_out;
  int checks = 0, errors = 0, lowcnt = 0, cyc = 0;

  always #2 clk = ~clk;

  wdt_freq_recover #(.SHORT_TICKS(SHORT), .LONG_TICKS(LONG), .RST_CYCLES(RSTC)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .ref_tick(ref_tick), .prog_en(prog_en), .hw_n(HWN), .hw_m(HWM),
    .sys_rst_n(sys_rst_n), .n_out(n_out), .m_out(m_out));

  always @(negedge clk) if (!sys_rst_n) lowcnt++;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      errors++;
      $display("FAIL watchdog: run hung, actual %0d cycles expected fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1; reg_we = 0; ref_tick = 0;
    @(negedge clk); @(negedge clk); rst = 0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); ref_tick = 1;
      @(negedge clk); ref_tick = 0;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] d;
    do_reset();
    // R1 reset state
    rd(2'd0, d); check("R1 ctrl reset", d, 8'h20);
    rd(2'd1, d); check("R1 rcv reset", d, 8'h00);
    rd(2'd2, d); check("R1 nlo reset", d, 8'h00);
    check("R1 sys_rst_n", sys_rst_n, 1);
    check("R1 n_out", n_out, HWN);
    check("R1 m_out", m_out, HWM);
    // R2 register map and read-only alarm
    wr(2'd1, 8'hAD); rd(2'd1, d); check("R2 rcv byte", d, 8'hAD);
    wr(2'd2, 8'h5C); rd(2'd2, d); check("R2 nlo byte", d, 8'h5C);
    rd(2'd3, d); check("R2 addr3 zero", d, 8'h00);
    wr(2'd0, 8'h02); rd(2'd0, d); check("R2 alarm write ignored", d, 8'h00);
    wr(2'd0, 8'hB6); rd(2'd0, d); check("R2 ctrl fields", d, 8'hB4);
    // R12 follow prog_en
    prog_en = 1; idle(2);
    check("R12 prog n", n_out, 9'h15C); check("R12 prog m", m_out, 7'h2D);
    prog_en = 0; idle(2);
    check("R12 hw n", n_out, HWN);
    // R5 disabled: no expiry
    wr(2'd0, 8'h10); ticks(20);
    rd(2'd0, d); check("R5 no alarm when disabled", d[1], 0);
    check("R5 no reset when disabled", lowcnt, 0);

    // table walk
    for (int v = 0; v < NV; v++) begin
      logic [2:0] code; logic sc, act, rcv, pe, kick;
      int t, base; logic [8:0] en_n; logic [6:0] em;
      {code, sc, act, rcv, pe, kick} = VEC[v];
      do_reset();
      prog_en = pe;
      wr(2'd1, {rcv, PGM});
      wr(2'd2, PGN[7:0]);
      wr(2'd0, {PGN[8], code, sc, act, 1'b0, 1'b1});
      t = (code == 0) ? 1 : code * (sc ? LONG : SHORT);
      base = lowcnt;
      ticks(t - 1);
      rd(2'd0, d); check("R3 no early alarm", d[1], 0);
      check("R3 no early reset", lowcnt - base, 0);
      if (kick) begin
        wr(2'd0, {PGN[8], code, sc, act, 1'b0, 1'b1});
        ticks(t - 1);
        rd(2'd0, d); check("R6 kick restarts count", d[1], 0);
      end
      ticks(1);
      rd(2'd0, d);
      if (code == 0) check("R4 test mode expiry", d[1], 1);
      else check("R3 alarm at timeout", d[1], 1);
      idle(RSTC + 4);
      check("R8 reset low length", lowcnt - base, RSTC);
      check("R8 reset released", sys_rst_n, 1);
      if (act) begin en_n = pe ? PGN : HWN; em = pe ? PGM : HWM; end
      else if (rcv) begin en_n = PGN; em = PGM; end
      else begin en_n = HWN; em = HWM; end
      prog_en = ~pe; idle(3);
      if (act) begin en_n = ~pe ? PGN : HWN; em = ~pe ? PGM : HWM; end
      if (act) check("R9 n follows after reset-only", n_out, en_n);
      else if (rcv) check("R11 n locked to programmed", n_out, en_n);
      else check("R10 n locked to hw", n_out, en_n);
      if (act) check("R9 m", m_out, em);
      else if (rcv) check("R11 m", m_out, em);
      else check("R10 m", m_out, em);
      ticks(3 * t + 2);
      check("R7 no re-arm while expired", lowcnt - base, RSTC);
    end

    // R7 alarm clear rules
    do_reset();
    wr(2'd0, 8'h01); ticks(1);
    rd(2'd0, d); check("R7 alarm set", d[1], 1);
    wr(2'd0, 8'h30); rd(2'd0, d); check("R7 alarm kept on nonzero code", d[1], 1);
    wr(2'd0, 8'h00); rd(2'd0, d); check("R7 alarm cleared by code 000", d[1], 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule